// File: doc/BRIEF.md
# Strobe-Handshake FIFO

This block is a first-in, first-out buffer of 64 words of 9 bits whose two sides are paced by level strobes rather than by clocked enables. A producer raises a shift-in strobe to hand over a word and lowers it to commit that word. A consumer raises a shift-out strobe to accept the word shown on the output and lowers it to release that word. Two ready outputs tell each side when it may act: input-ready toward the producer and output-ready toward the consumer. Both strobes pass through a two-flop synchronizer into one system clock domain. Two finite state machines then follow each strobe through its phases.

The write machine has four states. `W_READY` has input-ready high. `W_HELD` means a word is captured and the machine waits for the strobe to fall. `W_FULL` means every slot is used. `W_PULSE` means space has just opened while the strobe is still high. Its transitions are: capture (`W_READY`→`W_HELD`), commit (`W_HELD`→`W_READY` or `W_FULL`), release with strobe low (`W_FULL`→`W_READY`), release with strobe high (`W_FULL`→`W_PULSE`) and pulse end (`W_PULSE`→`W_HELD`).

The read machine also has four states. `R_EMPTY` means no word is presented. `R_VALID` means a word is presented with output-ready high. `R_TAKEN` means the consumer holds the strobe high over the presented word. `R_PULSE` is a one-cycle presentation while the strobe is already high. Its transitions are: present (`R_EMPTY`→`R_VALID`), fall-through present (`R_EMPTY`→`R_PULSE`), accept (`R_VALID`→`R_TAKEN`), pulse end (`R_PULSE`→`R_TAKEN`) and release (`R_TAKEN`→`R_EMPTY`).

Chains of these buffers can be connected for more depth, one buffer's output-ready driving the next one's shift-in. The one-cycle ready pulses make that chaining work when the opposite strobe is held high. The block also provides a half-full flag and a near-limit flag that is high when the buffer is nearly empty or nearly full.

Top module: `shift_fifo`

## Requirements
- R1: While master reset is asserted and immediately after it is released, input-ready is 1, output-ready is 0, the data output is all zeros, half-full is 0 and near-limit is 1.
- R2: If the shift-in strobe is already high when reset is released, the data input is captured and input-ready goes low. The word is committed and shown on the output once the strobe falls. If the strobe is low at release, nothing is stored.
- R3: A high shift-in strobe seen while input-ready is high captures the data input and drops input-ready. When the strobe falls, the write pointer advances and input-ready returns high unless the buffer is now full. Words leave in the order they were committed.
- R4: With 64 words held, input-ready stays 0, a shift-in strobe is ignored and the occupancy never exceeds 64.
- R5: A high shift-out strobe seen while output-ready is high drops output-ready. The presented word stays on the data output until that strobe falls.
- R6: The fall of the shift-out strobe removes the presented word, and the next stored word is then shown with output-ready high. When no word remains, output-ready stays 0 and the data output keeps the last word shown.
- R7: Fall-through with shift-out low: a word committed into an empty buffer appears on the output with output-ready high, and output-ready stays high until shift-out rises.
- R8: Fall-through with shift-out high: the word appears on the output with output-ready high for exactly one clock cycle. Words committed after it are not shown until shift-out falls.
- R9: Bubble-through with shift-in low: when a word is removed from a full buffer, input-ready goes high and stays high until shift-in rises.
- R10: Bubble-through with shift-in high: when a word is removed from a full buffer, input-ready is high for exactly one clock cycle, and the data input is captured in that cycle.
- R11: Half-full is 1 exactly when the occupancy is 32 or more. The occupancy counts the presented word until the shift-out fall that removes it.
- R12: Near-limit is 1 exactly when the occupancy is 8 or fewer, or 56 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are synchronized to it |
| mrst | input | 1 | Master reset, asynchronous, active high |
| shift_in | input | 1 | Producer strobe: high captures, low commits |
| din | input | 9 | Word offered by the producer |
| shift_out | input | 1 | Consumer strobe: high accepts, low releases |
| dout | output | 9 | Registered presented word |
| in_ready | output | 1 | Buffer can take a word |
| out_ready | output | 1 | A fresh word is on dout |
| half_full | output | 1 | Occupancy at or above half the depth |
| near_limit | output | 1 | Occupancy within the margin of empty or full |

## Verification
The bench builds the block with its defaults: 9-bit words, a 6-bit address (64 slots), two synchronizer stages and a margin of 8. At that depth the bench can fill the buffer to full in under a thousand cycles. Every flag threshold (8/9, 31/32, 55/56) and the full state can therefore be checked, and both bubble-through cases can be run on a truly full buffer. A full drain then confirms the order of the words, including the word captured during the one-cycle input-ready pulse.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

    typedef enum logic [1:0] {
        W_READY = 2'd0,
        W_HELD  = 2'd1,
        W_FULL  = 2'd2,
        W_PULSE = 2'd3
    } wr_state_t;

    typedef enum logic [1:0] {
        R_EMPTY = 2'd0,
        R_VALID = 2'd1,
        R_TAKEN = 2'd2,
        R_PULSE = 2'd3
    } rd_state_t;

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sif_ram.sv
module sif_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/sif_wr_ctrl.sv
module sif_wr_ctrl
    import shift_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic si_lvl,
    input  logic full,
    input  logic fills_up,
    output logic in_rdy,
    output logic wr_en,
    output logic wr_commit
);
    wr_state_t state_q, state_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= W_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_READY: if (si_lvl)  state_d = W_HELD;
            W_HELD:  if (!si_lvl) state_d = fills_up ? W_FULL : W_READY;
            W_FULL:  if (!full)   state_d = si_lvl ? W_PULSE : W_READY;
            W_PULSE: state_d = W_HELD;
            default: state_d = W_READY;
        endcase
    end

    always_comb begin
        in_rdy    = (state_q == W_READY) || (state_q == W_PULSE);
        wr_en     = ((state_q == W_READY) && si_lvl) || (state_q == W_PULSE);
        wr_commit = (state_q == W_HELD) && !si_lvl;
    end

    // R3 / R10: a ready cycle that meets a high strobe is followed by ready low
    p_ir_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (in_rdy && si_lvl) |=> !in_rdy);

    // R4: no readiness while every slot is used
    p_full_ir_r4: assert property (@(posedge clk) disable iff (rst)
        full |-> !in_rdy);
endmodule

// File: rtl/sif_rd_ctrl.sv
module sif_rd_ctrl
    import shift_fifo_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              so_lvl,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head,
    output logic              out_rdy,
    output logic [DATA_W-1:0] dout,
    output logic              rd_remove
);
    rd_state_t state_q, state_d;
    logic      load;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= R_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_EMPTY: if (have_data) state_d = so_lvl ? R_PULSE : R_VALID;
            R_VALID: if (so_lvl)    state_d = R_TAKEN;
            R_TAKEN: if (!so_lvl)   state_d = R_EMPTY;
            R_PULSE: state_d = R_TAKEN;
            default: state_d = R_EMPTY;
        endcase
    end

    always_comb begin
        out_rdy   = (state_q == R_VALID) || (state_q == R_PULSE);
        load      = (state_q == R_EMPTY) && have_data;
        rd_remove = (state_q == R_TAKEN) && !so_lvl;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= head;
        end
    end

    // R5 / R8: a presented word met by a high strobe drops ready next cycle
    p_or_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (out_rdy && so_lvl) |=> !out_rdy);

    // R6: the output word only changes together with a new presentation
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !out_rdy |=> (out_rdy || $stable(dout)));

    // R6: nothing is shown when nothing is stored
    p_empty_or_r6: assert property (@(posedge clk) disable iff (rst)
        !have_data |-> !out_rdy);
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
    parameter int DATA_W      = 9,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_MARGIN = 8
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              shift_in,
    input  logic [DATA_W-1:0] din,
    input  logic              shift_out,
    output logic [DATA_W-1:0] dout,
    output logic              in_ready,
    output logic              out_ready,
    output logic              half_full,
    output logic              near_limit
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;
    localparam int HALF  = DEPTH / 2;
    localparam logic [PTR_W-1:0] DEPTH_C = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_C  = PTR_W'(HALF);
    localparam logic [PTR_W-1:0] LOW_C   = PTR_W'(EDGE_MARGIN);
    localparam logic [PTR_W-1:0] HIGH_C  = PTR_W'(DEPTH - EDGE_MARGIN);

    logic             si_lvl, so_lvl;
    logic [PTR_W-1:0] wptr, rptr, count, count_after;
    logic             full, fills_up;
    logic             wr_en, wr_commit, rd_remove;
    logic [DATA_W-1:0] head;

    sif_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
        .clk(clk), .rst(mrst), .d(shift_in), .q(si_lvl)
    );

    sif_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
        .clk(clk), .rst(mrst), .d(shift_out), .q(so_lvl)
    );

    sif_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (din),
        .raddr (rptr[ADDR_W-1:0]),
        .rdata (head)
    );

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_commit) wptr <= wptr + PTR_W'(1);
            if (rd_remove) rptr <= rptr + PTR_W'(1);
        end
    end

    always_comb begin
        count       = wptr - rptr;
        full        = (count == DEPTH_C);
        count_after = count + PTR_W'(1) - PTR_W'(rd_remove);
        fills_up    = (count_after == DEPTH_C);
        half_full   = (count >= HALF_C);
        near_limit  = (count <= LOW_C) || (count >= HIGH_C);
    end

    sif_wr_ctrl u_wr (
        .clk       (clk),
        .rst       (mrst),
        .si_lvl    (si_lvl),
        .full      (full),
        .fills_up  (fills_up),
        .in_rdy    (in_ready),
        .wr_en     (wr_en),
        .wr_commit (wr_commit)
    );

    sif_rd_ctrl #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst       (mrst),
        .so_lvl    (so_lvl),
        .have_data (count != '0),
        .head      (head),
        .out_rdy   (out_ready),
        .dout      (dout),
        .rd_remove (rd_remove)
    );

    // R4: occupancy bounded by the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (mrst)
        count <= DEPTH_C);

    // R6: a removal never happens on an empty store
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (mrst)
        rd_remove |-> (count != '0));
endmodule

// File: tb/shift_fifo_tb.sv
`timescale 1ns/1ps
module shift_fifo_tb;
    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       in_ready, out_ready, half_full, near_limit;

    int checks = 0;
    int errors = 0;
    int or_cnt = 0;
    int ir_cnt = 0;

    always #2 clk = ~clk;

    shift_fifo u_dut (
        .clk(clk), .mrst(mrst), .shift_in(shift_in), .din(din),
        .shift_out(shift_out), .dout(dout), .in_ready(in_ready),
        .out_ready(out_ready), .half_full(half_full), .near_limit(near_limit)
    );

    // entry: [20] push(1)/pop(0), [19:11] data in, [10:2] dout, [1] out_ready, [0] in_ready
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 9'h1A5, 9'h1A5, 1'b1, 1'b1},
        {1'b1, 9'h0F0, 9'h1A5, 1'b1, 1'b1},
        {1'b1, 9'h133, 9'h1A5, 1'b1, 1'b1},
        {1'b0, 9'h000, 9'h0F0, 1'b1, 1'b1},
        {1'b0, 9'h000, 9'h133, 1'b1, 1'b1},
        {1'b0, 9'h000, 9'h133, 1'b0, 1'b1},
        {1'b1, 9'h055, 9'h055, 1'b1, 1'b1},
        {1'b0, 9'h000, 9'h055, 1'b0, 1'b1}
    };

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (out_ready) or_cnt++;
            if (in_ready)  ir_cnt++;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [8:0] d);
        din = d;
        shift_in = 1'b1;
        tick(6);
        shift_in = 1'b0;
        tick(6);
    endtask

    task automatic pop();
        shift_out = 1'b1;
        tick(6);
        shift_out = 1'b0;
        tick(6);
    endtask

    function automatic logic [8:0] item(input int i);
        return 9'(i * 7 + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(3);
        chk("R1", "in_ready in reset", int'(in_ready), 1);
        chk("R1", "out_ready in reset", int'(out_ready), 0);
        mrst = 1'b0;
        tick(2);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "out_ready", int'(out_ready), 0);
        chk("R1", "dout", int'(dout), 0);
        chk("R1", "half_full", int'(half_full), 0);
        chk("R1", "near_limit", int'(near_limit), 1);

        // R3, R6, R7: vector table walk
        for (int v = 0; v < 8; v++) begin
            if (VEC[v][20]) push(VEC[v][19:11]);
            else            pop();
            chk("R3/R6/R7 table", "dout", int'(dout), int'(VEC[v][10:2]));
            chk("R6/R7 table", "out_ready", int'(out_ready), int'(VEC[v][1]));
            chk("R3 table", "in_ready", int'(in_ready), int'(VEC[v][0]));
        end

        // R5: word held while shift-out is high
        push(9'h0AA);
        chk("R7", "out_ready after fall-through", int'(out_ready), 1);
        shift_out = 1'b1;
        tick(6);
        chk("R5", "out_ready after shift-out rise", int'(out_ready), 0);
        chk("R5", "dout held", int'(dout), 'h0AA);
        shift_out = 1'b0;
        tick(6);
        chk("R6", "out_ready once empty", int'(out_ready), 0);
        chk("R6", "dout keeps last word", int'(dout), 'h0AA);

        // R8: fall-through with shift-out held high
        shift_out = 1'b1;
        tick(6);
        or_cnt = 0;
        push(9'h111);
        tick(4);
        chk("R8", "out_ready pulse cycles", or_cnt, 1);
        chk("R8", "dout after pulse", int'(dout), 'h111);
        push(9'h122);
        chk("R8", "queued word not shown", int'(dout), 'h111);
        chk("R8", "out_ready low while queued", int'(out_ready), 0);
        shift_out = 1'b0;
        tick(6);
        chk("R8", "next word after release", int'(dout), 'h122);
        chk("R8", "out_ready after release", int'(out_ready), 1);
        pop();
        chk("R6", "out_ready after drain", int'(out_ready), 0);

        // R11, R12, R4: fill
        for (int i = 0; i < 64; i++) begin
            push(item(i));
            if (i + 1 == 8)  chk("R12", "near_limit at 8", int'(near_limit), 1);
            if (i + 1 == 9)  chk("R12", "near_limit at 9", int'(near_limit), 0);
            if (i + 1 == 31) chk("R11", "half_full at 31", int'(half_full), 0);
            if (i + 1 == 32) chk("R11", "half_full at 32", int'(half_full), 1);
            if (i + 1 == 55) chk("R12", "near_limit at 55", int'(near_limit), 0);
            if (i + 1 == 56) chk("R12", "near_limit at 56", int'(near_limit), 1);
        end
        chk("R4", "in_ready when full", int'(in_ready), 0);
        chk("R3", "first word presented", int'(dout), int'(item(0)));

        // R4 + R10: strobe while full is ignored, then bubble-through with shift-in high
        din = 9'h1EE;
        shift_in = 1'b1;
        tick(6);
        chk("R4", "in_ready with strobe while full", int'(in_ready), 0);
        ir_cnt = 0;
        pop();
        tick(4);
        chk("R10", "in_ready pulse cycles", ir_cnt, 1);
        chk("R10", "in_ready low after pulse", int'(in_ready), 0);
        shift_in = 1'b0;
        tick(6);
        chk("R4", "full again after commit", int'(in_ready), 0);
        chk("R12", "near_limit when full", int'(near_limit), 1);

        // R9: bubble-through with shift-in low
        pop();
        chk("R9", "in_ready after removal", int'(in_ready), 1);
        tick(10);
        chk("R9", "in_ready stays high", int'(in_ready), 1);

        // R3: drain order, ending with the word captured in the pulse
        for (int k = 2; k < 64; k++) begin
            chk("R3", "drain order", int'(dout), int'(item(k)));
            pop();
        end
        chk("R10", "captured pulse word", int'(dout), 'h1EE);
        chk("R6", "out_ready on last word", int'(out_ready), 1);
        pop();
        chk("R6", "out_ready empty", int'(out_ready), 0);
        chk("R6", "dout holds last", int'(dout), 'h1EE);
        chk("R11", "half_full empty", int'(half_full), 0);

        // R2: shift-in high across reset release
        mrst = 1'b1;
        din = 9'h0C3;
        shift_in = 1'b1;
        tick(3);
        mrst = 1'b0;
        tick(6);
        chk("R2", "in_ready low after held strobe", int'(in_ready), 0);
        chk("R2", "out_ready before commit", int'(out_ready), 0);
        shift_in = 1'b0;
        tick(8);
        chk("R2", "in_ready after fall", int'(in_ready), 1);
        chk("R2", "out_ready after commit", int'(out_ready), 1);
        chk("R2", "dout captured word", int'(dout), 'h0C3);

        // R2: shift-in low across reset release
        mrst = 1'b1;
        din = 9'h155;
        tick(3);
        mrst = 1'b0;
        tick(10);
        chk("R2", "nothing stored out_ready", int'(out_ready), 0);
        chk("R2", "in_ready high", int'(in_ready), 1);
        chk("R2", "dout cleared", int'(dout), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule